// File: doc/BRIEF.md
# Epoch-Based Cold Range Detector

This block watches the stream of memory accesses and records, with one bit per aligned 512 KiB region of the address space, which regions were used during the current epoch. The epoch length is decided outside the block and arrives as a one-cycle pulse. On that pulse the block freezes the epoch's record, starts a fresh record for the next epoch, and walks the frozen record one region per cycle from the lowest index up. Every region that was never used is offered on a valid/ready output as a candidate for heavy recompression.

A recompression engine downstream takes the candidates. The block caps how many candidates can be handed over in each fixed window of cycles, so recompression traffic cannot take all of the memory bandwidth. When the cap is reached the walk pauses on the pending candidate and resumes in the next window. No candidate is dropped. An epoch pulse that arrives while a walk is still running is ignored and recorded in a sticky flag.

Top module: `cold_range_detector`

## Requirements
- R1: After reset `cand_valid`, `scan_busy` and `overrun` are 0, and the window counter starts at cycle 0 of window 0.
- R2: An access with `acc_valid` high marks the region whose index is `acc_addr[ADDR_W-1:RANGE_SHIFT]` (RANGE_SHIFT = 19, so 32 regions for a 24-bit address). The offset bits below RANGE_SHIFT have no effect.
- R3: After an accepted epoch pulse, the indices handed over are exactly the regions left unmarked in that epoch. Each appears once, in strictly ascending order.
- R4: An access in the same cycle as the accepted epoch pulse belongs to the ending epoch. Accesses in any later cycle, including cycles during the walk, belong to the next epoch, whose record starts empty.
- R5: Windows are WIN_CYCLES cycles long and are counted from the first clock edge after reset. At most WIN_BUDGET handovers (`cand_valid && cand_ready`) occur in any one window.
- R6: While `cand_valid` is high and `cand_ready` is low, `cand_valid` stays high and `cand_idx` stays unchanged on the next cycle.
- R7: An epoch pulse that arrives while `scan_busy` is high leaves the running walk and its candidate list unchanged. It sets `overrun`, which stays 1 until reset.
- R8: `scan_busy` rises in the cycle after an accepted pulse and covers the walk. The walk advances one region per cycle, so an epoch in which every region was marked keeps `scan_busy` high for exactly NUM_RANGES cycles and issues no candidate. `cand_valid` is 0 whenever `scan_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| epoch_end | input | 1 | One-cycle pulse that closes the current epoch |
| cand_ready | input | 1 | The downstream engine accepts a candidate |
| cand_valid | output | 1 | A cold-region candidate is offered |
| cand_idx | output | IDX_W | Index of the offered region |
| scan_busy | output | 1 | A walk over the frozen record is running |
| overrun | output | 1 | Sticky flag: an epoch pulse arrived during a walk |

## Verification
Two pairs of functions can act in the same cycle. The first pair is recording an access and closing the epoch. The bench raises `acc_valid` for region 31 in the same cycle as `epoch_end` and expects region 31 to be missing from the candidate list. It then marks regions 1 and 2 while the walk runs and expects exactly those two to be missing from the next epoch's list. The second pair is walking and accepting a new epoch pulse. The bench pulses `epoch_end` in the middle of a walk and checks that `overrun` rises and that the candidate list is identical to the list without the pulse.

// File: rtl/crd_pkg.sv
package crd_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_st_e;
endpackage

// File: rtl/crd_track.sv
module crd_track #(
    parameter int NUM_RANGES = 32,
    parameter int IDX_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [IDX_W-1:0]      acc_idx,
    input  logic                  take,
    input  logic                  clear,
    output logic [NUM_RANGES-1:0] frozen
);
    typedef struct packed {
        logic [NUM_RANGES-1:0] live;
        logic [NUM_RANGES-1:0] snap;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [NUM_RANGES-1:0] hit;

    always_comb begin
        hit   = acc_valid ? (NUM_RANGES'(1) << acc_idx) : '0;
        trk_d = trk_q;
        trk_d.live = trk_q.live | hit;
        if (take) begin
            trk_d.snap = trk_q.live | hit;
            trk_d.live = '0;
        end else if (clear) begin
            trk_d.snap = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign frozen = trk_q.snap;

    // R4: the new epoch's record starts empty
    p_fresh_epoch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (trk_q.live == '0));
endmodule

// File: rtl/crd_rate.sv
module crd_rate #(
    parameter int WIN_CYCLES = 64,
    parameter int WIN_BUDGET = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic budget_ok
);
    localparam int WC_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int BC_W = $clog2(WIN_BUDGET + 1);

    typedef struct packed {
        logic [WC_W-1:0] win;
        logic [BC_W-1:0] used;
    } rate_t;

    rate_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (rt_q.win == WC_W'(WIN_CYCLES - 1)) begin
            rt_d.win  = '0;
            rt_d.used = '0;
        end else begin
            rt_d.win = rt_q.win + 1'b1;
            if (fire) rt_d.used = rt_q.used + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign budget_ok = (rt_q.used < BC_W'(WIN_BUDGET));

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.used <= BC_W'(WIN_BUDGET));
    p_fire_in_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (rt_q.used < BC_W'(WIN_BUDGET)));
endmodule

// File: rtl/crd_walk.sv
module crd_walk
    import crd_pkg::*;
#(
    parameter int NUM_RANGES = 32,
    parameter int IDX_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             epoch_end,
    input  logic             cur_marked,
    input  logic             budget_ok,
    input  logic             cand_ready,
    output logic             cand_valid,
    output logic [IDX_W-1:0] cur_idx,
    output logic             fire,
    output logic             take,
    output logic             done,
    output logic             busy,
    output logic             overrun
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_RANGES - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [IDX_W-1:0] idx;
        logic             ovr;
    } walk_t;

    walk_t wk_d, wk_q;
    logic  step;

    always_comb begin
        wk_d       = wk_q;
        take       = 1'b0;
        done       = 1'b0;
        cand_valid = 1'b0;
        step       = 1'b0;
        if (wk_q.st == WALK_IDLE) begin
            if (epoch_end) begin
                take      = 1'b1;
                wk_d.st   = WALK_RUN;
                wk_d.idx  = '0;
            end
        end else begin
            if (epoch_end) wk_d.ovr = 1'b1;
            cand_valid = !cur_marked && budget_ok;
            step       = cur_marked || (cand_valid && cand_ready);
            if (step) begin
                if (wk_q.idx == LAST) begin
                    wk_d.st = WALK_IDLE;
                    done    = 1'b1;
                end else begin
                    wk_d.idx = wk_q.idx + 1'b1;
                end
            end
        end
        fire = cand_valid && cand_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q.st  <= WALK_IDLE;
            wk_q.idx <= '0;
            wk_q.ovr <= 1'b0;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign cur_idx = wk_q.idx;
    assign busy    = (wk_q.st == WALK_RUN);
    assign overrun = wk_q.ovr;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cur_idx)));
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cand_valid);
    p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!busy || (cur_idx == IDX_W'($past(cur_idx) + 1'b1))));
endmodule

// File: rtl/cold_range_detector.sv
module cold_range_detector #(
    parameter int ADDR_W      = 24,
    parameter int RANGE_SHIFT = 19,
    parameter int WIN_CYCLES  = 64,
    parameter int WIN_BUDGET  = 4,
    localparam int IDX_W      = ADDR_W - RANGE_SHIFT,
    localparam int NUM_RANGES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              epoch_end,
    input  logic              cand_ready,
    output logic              cand_valid,
    output logic [IDX_W-1:0]  cand_idx,
    output logic              scan_busy,
    output logic              overrun
);
    logic [NUM_RANGES-1:0] frozen;
    logic [IDX_W-1:0]      cur_idx;
    logic                  fire, take, done, budget_ok;
    logic                  unused_offset;

    assign unused_offset = ^acc_addr[RANGE_SHIFT-1:0];

    crd_track #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_idx  (acc_addr[ADDR_W-1:RANGE_SHIFT]),
        .take     (take),
        .clear    (done),
        .frozen   (frozen)
    );

    crd_rate #(.WIN_CYCLES(WIN_CYCLES), .WIN_BUDGET(WIN_BUDGET)) rate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .budget_ok(budget_ok)
    );

    crd_walk #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .epoch_end (epoch_end),
        .cur_marked(frozen[cur_idx]),
        .budget_ok (budget_ok),
        .cand_ready(cand_ready),
        .cand_valid(cand_valid),
        .cur_idx   (cur_idx),
        .fire      (fire),
        .take      (take),
        .done      (done),
        .busy      (scan_busy),
        .overrun   (overrun)
    );

    assign cand_idx = cur_idx;
endmodule

// File: tb/cold_range_detector_tb_top.sv
module cold_range_detector_tb_top;
    localparam int ADDR_W = 24;
    localparam int SHIFT  = 19;
    localparam int NR     = 32;
    localparam int WIN    = 64;
    localparam int BUDGET = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic epoch_end = 1'b0;
    logic cand_ready = 1'b0;
    logic cand_valid, scan_busy, overrun;
    logic [4:0] cand_idx;

    int checks = 0, errors = 0;
    int got [0:63];
    int got_n = 0;
    int edges = 0;
    int cur_win = -1, win_fires = 0;
    int wd = 0;
    logic [NR-1:0] marked;

    cold_range_detector #(.ADDR_W(ADDR_W), .RANGE_SHIFT(SHIFT),
        .WIN_CYCLES(WIN), .WIN_BUDGET(BUDGET)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .epoch_end(epoch_end), .cand_ready(cand_ready), .cand_valid(cand_valid),
        .cand_idx(cand_idx), .scan_busy(scan_busy), .overrun(overrun));

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // handover monitor, also judging the per-window cap (R5)
    always @(negedge clk) begin
        if (rst_n && cand_valid && cand_ready) begin
            if (got_n < 64) got[got_n] = cand_idx;
            got_n++;
            if (edges / WIN != cur_win) begin
                cur_win   = edges / WIN;
                win_fires = 0;
            end
            win_fires++;
            if (win_fires > BUDGET) check(1'b0, "R5 handovers in one window", win_fires, BUDGET);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            check(1'b0, "watchdog", wd, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic touch(input int idx, input int off);
        @(posedge clk); #1;
        acc_valid = 1'b1;
        acc_addr  = ADDR_W'((idx << SHIFT) | off);
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic pulse(input bool_with_acc, input int idx);
        @(posedge clk); #1;
        epoch_end = 1'b1;
        if (bool_with_acc) begin
            acc_valid = 1'b1;
            acc_addr  = ADDR_W'(idx << SHIFT);
        end
        @(posedge clk); #1;
        epoch_end = 1'b0;
        acc_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (scan_busy) @(negedge clk);
    endtask

    task automatic compare_list(input logic [NR-1:0] m, input string req);
        int n = 0;
        bit ok = 1'b1;
        for (int i = 0; i < NR; i++) begin
            if (!m[i]) begin
                if (n >= got_n || got[n] != i) begin
                    ok = 1'b0;
                    check(1'b0, req, (n < got_n) ? got[n] : -1, i);
                end
                n++;
            end
        end
        check(got_n == n, {req, " candidate count"}, got_n, n);
        if (ok) check(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        check(cand_valid == 1'b0, "R1 cand_valid after reset", cand_valid, 0);
        check(scan_busy == 1'b0, "R1 scan_busy after reset", scan_busy, 0);
        check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
    endtask

    // R2, R3, R4: marks, same-cycle access at the pulse, accesses during the walk
    task automatic t_basic();
        touch(0, 0);
        touch(3, 'h7FFFF);
        touch(5, 'h123);
        got_n = 0;
        cand_ready = 1'b1;
        pulse(1, 31);
        touch(1, 0);
        touch(2, 'h40);
        wait_idle();
        marked = '0;
        marked[0] = 1; marked[3] = 1; marked[5] = 1; marked[31] = 1;
        compare_list(marked, "R3 R2 R4 cold list, epoch A");
        check(overrun == 1'b0, "R7 no overrun without extra pulse", overrun, 0);
    endtask

    // R4 next epoch gets walk-time accesses; R7 ignored pulse mid-walk
    task automatic t_overrun();
        got_n = 0;
        pulse(0, 0);
        repeat (40) @(posedge clk);
        #1;
        check(scan_busy == 1'b1, "R7 walk still running before extra pulse", scan_busy, 1);
        pulse(0, 0);
        wait_idle();
        marked = '0;
        marked[1] = 1; marked[2] = 1;
        compare_list(marked, "R4 R7 cold list, epoch B");
        check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    endtask

    // R6 backpressure, R7 stickiness
    task automatic t_backpressure();
        int first;
        bit held = 1'b1;
        cand_ready = 1'b0;
        got_n = 0;
        pulse(0, 0);
        @(negedge clk);
        while (!cand_valid) @(negedge clk);
        first = cand_idx;
        repeat (20) begin
            @(negedge clk);
            if (!cand_valid || cand_idx != first) held = 1'b0;
        end
        check(held, "R6 candidate held under backpressure", cand_idx, first);
        @(posedge clk); #1;
        cand_ready = 1'b1;
        wait_idle();
        compare_list('0, "R6 R3 no candidate lost, epoch C");
        check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    endtask

    // R8 full walk length, no candidates
    task automatic t_all_marked();
        int busy_cycles = 0;
        bit stray = 1'b0;
        for (int i = 0; i < NR; i++) touch(i, i * 7);
        got_n = 0;
        pulse(0, 0);
        @(negedge clk);
        while (scan_busy) begin
            busy_cycles++;
            if (cand_valid) stray = 1'b1;
            @(negedge clk);
        end
        check(busy_cycles == NR, "R8 walk length", busy_cycles, NR);
        check(!stray && got_n == 0, "R8 no candidate when all marked", got_n, 0);
        check(!cand_valid, "R8 cand_valid low when idle", cand_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_overrun();
        t_backpressure();
        t_all_marked();
        check(cur_win >= 0, "R5 windows observed", cur_win, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule